// File: doc/BRIEF.md
# DMA Channel Request and Control Front End

This block is the control side of one DMA channel. It holds a 16-bit control word that software writes and reads over a simple register strobe bus. The word chooses the transfer request source, the bus hold policy, the transfer unit size, the interrupt enable and the channel enable. When the channel is built for external requests, the word also chooses how the external request pin is sensed and when and with what polarity the acknowledge pin is driven.

Address generation, the transfer counter and the bus sequencer are not part of this block. The bus sequencer sits next to it. It takes `chan_req` as the request to arbitrate. It pulses `bus_rd_cyc` and `bus_wr_cyc` once for each read and write bus cycle of a unit transfer. It pulses `xfer_done` when the whole transfer finishes normally. The block returns `bus_hold` for burst operation and `word_size` for the unit width.

A transfer that ends sets a completion flag and can raise an interrupt. Software may clear that flag only by reading the word while the flag is set and then writing a 0 to the flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x0000. `chan_req`, `bus_hold`, `irq` and `ack_out` are all 0.
- R2: A write loads the resource code (bits 11:8), acknowledge phase (7), acknowledge polarity (6), request detect mode (5), burst (4), word size (3), interrupt enable (2) and channel enable (0). Bits 15:12 always read 0, bit 1 reads the completion flag, and `word_size` follows bit 3.
- R3: A write whose resource code is 1110 or 1111 leaves the stored code unchanged. The other fields of that write still load.
- R4: Resource code 1011 selects the `timer_evt` input, 1100 is a permanent internal request, 1101 selects `adc_evt`, and 0000 selects the external pin. Every other code requests nothing.
- R5: `chan_req` is the selected request gated by channel enable (bit 0 = 1) and by the completion flag being 0.
- R6: In level mode (bit 5 = 0), the external request is active while `ext_req_n` is low. It follows the pin with two clock cycles of synchroniser latency.
- R7: In edge mode (bit 5 = 1), each falling edge of `ext_req_n` latches one pending request, visible three cycles after the pin falls. It stays pending after the pin returns high, until an acknowledged bus cycle consumes it.
- R8: With the external source selected and the channel enabled, acknowledge is active during `bus_rd_cyc` when bit 7 = 0 and during `bus_wr_cyc` when bit 7 = 1. With any other source it is never active.
- R9: Bit 6 = 0 makes `ack_out` active-high; bit 6 = 1 makes it active-low (idle high).
- R10: With bit 4 = 1, `bus_hold` rises the cycle after the first `bus_rd_cyc` seen while `chan_req` is 1. It stays high until `xfer_done` or until the channel is disabled. With bit 4 = 0, `bus_hold` stays 0.
- R11: `xfer_done` while enabled sets the completion flag. The flag clears only on a write with bit 1 = 0 that follows a register read (`reg_rd`) made while the flag was 1, with no write in between. A write of 1, or a write of 0 without that read, leaves it set.
- R12: `irq` equals interrupt enable AND completion flag.
- R13: When built with `EXT_REQ = 0`, bits 7:5 read 0 and ignore writes, code 0000 requests nothing, and `ack_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_rd | input | 1 | Control word read strobe (arms flag clear) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| ext_req_n | input | 1 | External request pin, active low, asynchronous |
| timer_evt | input | 1 | Timer compare/capture request |
| adc_evt | input | 1 | Conversion-complete request |
| bus_rd_cyc | input | 1 | Bus sequencer is in a read cycle |
| bus_wr_cyc | input | 1 | Bus sequencer is in a write cycle |
| xfer_done | input | 1 | Whole transfer finished normally |
| chan_req | output | 1 | Request towards the bus sequencer |
| bus_hold | output | 1 | Keep the bus between units (burst) |
| ack_out | output | 1 | Acknowledge pin, programmable polarity |
| word_size | output | 1 | 1 = 16-bit unit, 0 = byte |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
If the stored resource code is wrong, `chan_req` goes wrong in the same cycle as the request inputs change, so the sweep over every code and input pattern exposes it at once. If the clear-arming state is lost or set too easily, the flag on bit 1 and `irq` change on the very next write. A wrong synchroniser depth or edge latch moves the rising `chan_req` off the exact cycle the bench samples, two or three cycles after the pin falls. An edge latch that is never released shows up as `chan_req` staying high after the acknowledged cycle.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int CTL_W = 16;

    localparam logic [3:0] RS_EXT   = 4'b0000;
    localparam logic [3:0] RS_TIMER = 4'b1011;
    localparam logic [3:0] RS_AUTO  = 4'b1100;
    localparam logic [3:0] RS_ADC   = 4'b1101;

    typedef enum logic [2:0] {
        SRC_EXT,
        SRC_TIMER,
        SRC_AUTO,
        SRC_ADC,
        SRC_NONE
    } src_e;

    typedef struct packed {
        logic [3:0] rs;
        logic       ack_wr;
        logic       ack_low;
        logic       dreq_edge;
        logic       burst;
        logic       word;
        logic       ie;
        logic       de;
    } ctl_t;

    function automatic logic rs_reserved(input logic [3:0] rs);
        return rs[3] & rs[2] & rs[1];
    endfunction

    function automatic src_e rs_decode(input logic [3:0] rs);
        case (rs)
            RS_EXT:   return SRC_EXT;
            RS_TIMER: return SRC_TIMER;
            RS_AUTO:  return SRC_AUTO;
            RS_ADC:   return SRC_ADC;
            default:  return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter bit EXT_REQ = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    input  logic             xfer_done,
    output ctl_t             ctl,
    output logic             te
);

    logic       armed;
    logic [3:0] new_rs;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[15:12], reg_wdata[7:5]};
    assign new_rs = rs_reserved(reg_wdata[11:8]) ? ctl.rs : reg_wdata[11:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (reg_wr) begin
            ctl.rs    <= new_rs;
            ctl.burst <= reg_wdata[4];
            ctl.word  <= reg_wdata[3];
            ctl.ie    <= reg_wdata[2];
            ctl.de    <= reg_wdata[0];
            if (EXT_REQ) begin
                ctl.ack_wr    <= reg_wdata[7];
                ctl.ack_low   <= reg_wdata[6];
                ctl.dreq_edge <= reg_wdata[5];
            end else begin
                ctl.ack_wr    <= 1'b0;
                ctl.ack_low   <= 1'b0;
                ctl.dreq_edge <= 1'b0;
            end
        end
    end

    // Clear arming: a read that sees the flag set, spent by the next write.
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (reg_wr)
            armed <= 1'b0;
        else if (reg_rd && te)
            armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            te <= 1'b0;
        else if (xfer_done && ctl.de)
            te <= 1'b1;
        else if (reg_wr && armed && !reg_wdata[1])
            te <= 1'b0;
    end

    assign reg_rdata = {4'b0000, ctl.rs, ctl.ack_wr, ctl.ack_low, ctl.dreq_edge,
                        ctl.burst, ctl.word, ctl.ie, te, ctl.de};

    // R3
    reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && rs_reserved(reg_wdata[11:8])) |=> $stable(ctl.rs));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (te && !armed) |=> te);

    // R11
    flag_clear_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (te && reg_wr && reg_wdata[1]) |=> te);

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
    parameter bit EXT_REQ     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_req_n,
    input  logic edge_mode,
    input  logic take,
    output logic ext_req
);

    localparam int SH_W = SYNC_STAGES + 1;

    generate
        if (EXT_REQ) begin : g_ext
            logic [SH_W-1:0] sh;
            logic            synced;
            logic            prev;
            logic            fall;
            logic            pending;

            always_ff @(posedge clk) begin
                if (rst)
                    sh <= '1;
                else
                    sh <= {sh[SH_W-2:0], ext_req_n};
            end

            assign synced = sh[SYNC_STAGES-1];
            assign prev   = sh[SYNC_STAGES];
            assign fall   = prev & ~synced;

            always_ff @(posedge clk) begin
                if (rst || !edge_mode)
                    pending <= 1'b0;
                else if (fall)
                    pending <= 1'b1;
                else if (take)
                    pending <= 1'b0;
            end

            assign ext_req = edge_mode ? pending : ~synced;

            // R7
            edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
                (edge_mode && fall && !rst) |=> (pending || !edge_mode));

            // R7
            pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (edge_mode && pending && !take) |=> (pending || !edge_mode));
        end else begin : g_noext
            logic unused_in;
            assign unused_in = ^{clk, rst, ext_req_n, edge_mode, take};
            assign ext_req   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
    import dma_ctl_pkg::*;
#(
    parameter bit EXT_REQ = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rs,
    input  logic       de,
    input  logic       te,
    input  logic       burst,
    input  logic       ack_wr,
    input  logic       ack_low,
    input  logic       timer_evt,
    input  logic       adc_evt,
    input  logic       ext_req,
    input  logic       bus_rd_cyc,
    input  logic       bus_wr_cyc,
    input  logic       xfer_done,
    output logic       chan_req,
    output logic       ack_take,
    output logic       ack_out,
    output logic       bus_hold
);

    src_e src;
    logic raw_req;
    logic phase;
    logic ext_sel;

    assign src     = rs_decode(rs);
    assign ext_sel = EXT_REQ && (src == SRC_EXT);

    always_comb begin
        case (src)
            SRC_EXT:   raw_req = ext_sel & ext_req;
            SRC_TIMER: raw_req = timer_evt;
            SRC_AUTO:  raw_req = 1'b1;
            SRC_ADC:   raw_req = adc_evt;
            default:   raw_req = 1'b0;
        endcase
    end

    assign chan_req = raw_req & de & ~te;

    assign phase    = ack_wr ? bus_wr_cyc : bus_rd_cyc;
    assign ack_take = phase & de & ext_sel;
    assign ack_out  = ack_take ^ (ack_low & EXT_REQ);

    always_ff @(posedge clk) begin
        if (rst || !de || !burst || xfer_done)
            bus_hold <= 1'b0;
        else if (chan_req && bus_rd_cyc)
            bus_hold <= 1'b1;
    end

    // R10
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_hold && de && burst && !xfer_done) |=> bus_hold);

    // R10
    steal_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!burst) |=> (!bus_hold || burst));

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_cyc && !bus_wr_cyc) |-> (ack_out == (ack_low && EXT_REQ)));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_ctl_pkg::*;
#(
    parameter bit EXT_REQ     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        ext_req_n,
    input  logic        timer_evt,
    input  logic        adc_evt,
    input  logic        bus_rd_cyc,
    input  logic        bus_wr_cyc,
    input  logic        xfer_done,
    output logic        chan_req,
    output logic        bus_hold,
    output logic        ack_out,
    output logic        word_size,
    output logic        irq
);

    ctl_t ctl;
    logic te;
    logic ext_req;
    logic ack_take;

    dma_ctl_regs #(.EXT_REQ(EXT_REQ)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .xfer_done (xfer_done),
        .ctl       (ctl),
        .te        (te)
    );

    dma_req_detect #(.EXT_REQ(EXT_REQ), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .ext_req_n (ext_req_n),
        .edge_mode (ctl.dreq_edge),
        .take      (ack_take),
        .ext_req   (ext_req)
    );

    dma_req_gate #(.EXT_REQ(EXT_REQ)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .rs         (ctl.rs),
        .de         (ctl.de),
        .te         (te),
        .burst      (ctl.burst),
        .ack_wr     (ctl.ack_wr),
        .ack_low    (ctl.ack_low),
        .timer_evt  (timer_evt),
        .adc_evt    (adc_evt),
        .ext_req    (ext_req),
        .bus_rd_cyc (bus_rd_cyc),
        .bus_wr_cyc (bus_wr_cyc),
        .xfer_done  (xfer_done),
        .chan_req   (chan_req),
        .ack_take   (ack_take),
        .ack_out    (ack_out),
        .bus_hold   (bus_hold)
    );

    assign word_size = ctl.word;
    assign irq       = ctl.ie & te;

    // R5
    flag_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        te |-> !chan_req);

    // R12
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> reg_rdata[1]);

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        ext_req_n = 1'b1, timer_evt = 1'b0, adc_evt = 1'b0;
    logic        bus_rd_cyc = 1'b0, bus_wr_cyc = 1'b0, xfer_done = 1'b0;

    logic [15:0] rdata, rdata_nx;
    logic        chan_req, bus_hold, ack_out, word_size, irq;
    logic        chan_req_nx, bus_hold_nx, ack_out_nx, word_size_nx, irq_nx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_chan_ctl #(.EXT_REQ(1'b1), .SYNC_STAGES(2)) u_dma_chan_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .ext_req_n(ext_req_n),
        .timer_evt(timer_evt), .adc_evt(adc_evt), .bus_rd_cyc(bus_rd_cyc),
        .bus_wr_cyc(bus_wr_cyc), .xfer_done(xfer_done), .chan_req(chan_req),
        .bus_hold(bus_hold), .ack_out(ack_out), .word_size(word_size), .irq(irq)
    );

    dma_chan_ctl #(.EXT_REQ(1'b0), .SYNC_STAGES(2)) u_noext (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nx), .ext_req_n(ext_req_n),
        .timer_evt(timer_evt), .adc_evt(adc_evt), .bus_rd_cyc(bus_rd_cyc),
        .bus_wr_cyc(bus_wr_cyc), .xfer_done(xfer_done), .chan_req(chan_req_nx),
        .bus_hold(bus_hold_nx), .ack_out(ack_out_nx), .word_size(word_size_nx),
        .irq(irq_nx)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd();
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic exp_req(input logic [3:0] rs, input logic de,
                                     input logic t, input logic a, input logic ext);
        logic r;
        case (rs)
            4'b0000: r = ext;
            4'b1011: r = t;
            4'b1100: r = 1'b1;
            4'b1101: r = a;
            default: r = 1'b0;
        endcase
        return r & de;
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] cur_rs;
        @(negedge clk); cyc(2);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata, 16'h0000);
        chk("R1 chan_req", {15'b0, chan_req}, 16'h0);
        chk("R1 bus_hold", {15'b0, bus_hold}, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R1 ack_out", {15'b0, ack_out}, 16'h0);

        // R2 field load and readback; R13 option bits dropped without external requests
        wr(16'hFBFF);
        chk("R2 readback", rdata, 16'h0BFD);
        chk("R2 word_size", {15'b0, word_size}, 16'h1);
        chk("R13 noext readback", rdata_nx, 16'h0B1D);
        wr(16'h0B00);
        chk("R2 word_size low", {15'b0, word_size}, 16'h0);

        // R3 reserved codes keep the stored code, other fields load
        wr(16'h0E04);
        chk("R3 code 1110", rdata, 16'h0B04);
        wr(16'h0F08);
        chk("R3 code 1111", rdata, 16'h0B08);

        // R4/R5 sweep, external pin held low in level mode
        ext_req_n = 1'b0;
        cyc(4);
        cur_rs = 4'b1011;
        for (int code = 0; code < 16; code++) begin
            for (int p = 0; p < 8; p++) begin
                logic de, t, a;
                de = p[0]; t = p[1]; a = p[2];
                if (!(code >= 14)) cur_rs = code[3:0];
                wr({4'b0, code[3:0], 7'b0, de});
                timer_evt = t; adc_evt = a;
                #1;
                chk("R4 R5 chan_req", {15'b0, chan_req}, {15'b0, exp_req(cur_rs, de, t, a, 1'b1)});
                chk("R13 noext chan_req", {15'b0, chan_req_nx}, {15'b0, exp_req(cur_rs, de, t, a, 1'b0)});
            end
        end
        timer_evt = 1'b0; adc_evt = 1'b0;

        // R6 level mode latency
        wr(16'h0001);
        ext_req_n = 1'b1;
        cyc(4);
        chk("R6 idle", {15'b0, chan_req}, 16'h0);
        ext_req_n = 1'b0;
        @(negedge clk);
        chk("R6 one cycle", {15'b0, chan_req}, 16'h0);
        @(negedge clk);
        chk("R6 two cycles", {15'b0, chan_req}, 16'h1);
        ext_req_n = 1'b1;
        cyc(2);
        chk("R6 released", {15'b0, chan_req}, 16'h0);
        cyc(2);

        // R7 edge mode: one-cycle low pulse latched
        wr(16'h0021);
        cyc(2);
        ext_req_n = 1'b0;
        @(negedge clk);
        ext_req_n = 1'b1;
        @(negedge clk);
        chk("R7 not yet", {15'b0, chan_req}, 16'h0);
        @(negedge clk);
        chk("R7 latched", {15'b0, chan_req}, 16'h1);
        cyc(5);
        chk("R7 held", {15'b0, chan_req}, 16'h1);
        bus_wr_cyc = 1'b1;
        @(negedge clk);
        bus_wr_cyc = 1'b0;
        chk("R7 wrong phase keeps", {15'b0, chan_req}, 16'h1);
        bus_rd_cyc = 1'b1;
        #1;
        chk("R8 ack in read", {15'b0, ack_out}, 16'h1);
        @(negedge clk);
        bus_rd_cyc = 1'b0;
        chk("R7 consumed", {15'b0, chan_req}, 16'h0);

        // R8/R9 phase and polarity
        wr(16'h00C1);
        chk("R9 idle low-active", {15'b0, ack_out}, 16'h1);
        bus_rd_cyc = 1'b1; #1;
        chk("R8 no ack in read", {15'b0, ack_out}, 16'h1);
        bus_rd_cyc = 1'b0; bus_wr_cyc = 1'b1; #1;
        chk("R8 R9 ack in write", {15'b0, ack_out}, 16'h0);
        chk("R13 noext ack", {15'b0, ack_out_nx}, 16'h0);
        bus_wr_cyc = 1'b0;
        @(negedge clk);
        wr(16'h0001);
        bus_wr_cyc = 1'b1; #1;
        chk("R8 no ack in write", {15'b0, ack_out}, 16'h0);
        bus_wr_cyc = 1'b0;
        @(negedge clk);
        wr(16'h0B01);
        bus_rd_cyc = 1'b1; #1;
        chk("R8 other source", {15'b0, ack_out}, 16'h0);
        bus_rd_cyc = 1'b0;
        @(negedge clk);

        // R10 cycle steal never holds
        wr(16'h0C01);
        bus_rd_cyc = 1'b1;
        @(negedge clk);
        bus_rd_cyc = 1'b0;
        chk("R10 steal", {15'b0, bus_hold}, 16'h0);

        // R10 burst hold
        wr(16'h0C11);
        chk("R10 before", {15'b0, bus_hold}, 16'h0);
        bus_rd_cyc = 1'b1;
        @(negedge clk);
        bus_rd_cyc = 1'b0;
        chk("R10 rises", {15'b0, bus_hold}, 16'h1);
        cyc(3);
        chk("R10 stays", {15'b0, bus_hold}, 16'h1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R10 drops", {15'b0, bus_hold}, 16'h0);
        chk("R11 flag set", {15'b0, rdata[1]}, 16'h1);
        chk("R5 blocked by flag", {15'b0, chan_req}, 16'h0);
        chk("R12 irq off", {15'b0, irq}, 16'h0);

        // R11/R12 clear protocol
        wr(16'h0C05);
        chk("R11 zero without read", {15'b0, rdata[1]}, 16'h1);
        chk("R12 irq on", {15'b0, irq}, 16'h1);
        rd();
        wr(16'h0C07);
        chk("R11 write one", {15'b0, rdata[1]}, 16'h1);
        wr(16'h0C05);
        chk("R11 arm spent", {15'b0, rdata[1]}, 16'h1);
        rd();
        cyc(2);
        wr(16'h0C05);
        chk("R11 cleared", {15'b0, rdata[1]}, 16'h0);
        chk("R12 irq cleared", {15'b0, irq}, 16'h0);
        chk("R5 request back", {15'b0, chan_req}, 16'h1);
        wr(16'h0C04);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk("R11 disabled no set", {15'b0, rdata[1]}, 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule